// File: doc/BRIEF.md
# Multiplexed Host-Port Read Sequencer

This block is a bus master that carries out single read accesses to a DSP-style host port. The port shares one 16-bit bus between address and data. An internal client hands over an address through a valid/ready handshake. The sequencer then steps the bus through four phases, always in this order: address, data setup, data strobe and recovery. The word captured from the bus comes back as a one-cycle response pulse.

Each phase has its own 4-bit length setting. A setting of N gives a phase of N+1 bus clocks. Settings below a phase's minimum are raised to that minimum: 2 for address, 2 for setup, 1 for strobe and 0 for recovery. All four settings are sampled when the request is accepted. A wait input from the target can stretch the address phase or the strobe phase, but no other phase. Once wait drops, the phase lasts at least one more clock.

Top module: `hpi_rd_seq`

## Requirements
- R1: After reset `bus_cs_n`=1, `bus_ds_n`=1, `bus_ad_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: An access runs address, setup, strobe, recovery in order. In the address phase `bus_cs_n`=0, `bus_ad_oe`=1 and `bus_ad_o` equals the request address, starting from the very cycle in which `bus_cs_n` falls. In the setup phase `bus_cs_n`=0, `bus_ad_oe`=0 and `bus_ds_n`=1. In the strobe phase `bus_cs_n`=0 and `bus_ds_n`=0. In the recovery phase `bus_cs_n`=1.
- R3: With no wait, the address phase lasts max(`cfg_addr`,2)+1 clocks.
- R4: The setup phase lasts max(`cfg_setup`,2)+1 clocks.
- R5: With no wait, the strobe phase lasts max(`cfg_strobe`,1)+1 clocks, so it is never shorter than two clocks.
- R6: The recovery phase lasts `cfg_recov`+1 clocks. During it `bus_cs_n`=1 and `req_ready`=0. The block then returns to idle with `req_ready`=1.
- R7: Suppose `tgt_wait` is high in the first W clocks (W>0) of the address phase or of the strobe phase. That phase then lasts max(N+1, W+2) clocks, where N is the clamped setting. The phase never ends while wait is high, nor in the clock right after wait was last high.
- R8: `rsp_data` holds the value `bus_ad_i` had in the last strobe clock. `rsp_valid` is high for exactly one clock per access: the first recovery clock, in which `bus_cs_n` and `bus_ds_n` are already high.
- R9: `req_ready` is high only in idle, so a request made during an access or during recovery waits. Changes to the configuration inputs after acceptance do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge |
| req_addr | input | DW | Address to read |
| cfg_addr | input | PW | Address phase length setting |
| cfg_setup | input | PW | Data setup phase length setting |
| cfg_strobe | input | PW | Strobe phase length setting |
| cfg_recov | input | PW | Recovery phase length setting |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_data | output | DW | Captured read data |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_ds_n | output | 1 | Active-low data strobe |
| bus_ad_o | output | DW | Address driven onto the shared bus |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_ad_i | input | DW | Data read from the shared bus |
| tgt_wait | input | 1 | Target stall request, active high |

## Verification
The embedded properties check on every cycle that:
- the strobe only occurs inside chip select;
- the address is present in the cycle chip select falls;
- the address phase reaches three clocks and the strobe two;
- no request is taken while chip select is active;
- the strobe holds while wait is high and for one clock after it falls;
- the response pulse arrives with the strobe just released.

The exact phase lengths for each setting, including clamping, the stretch produced by a given wait pattern and the recovery gap, can only be shown by the bench's scenarios. The same applies to capture of the last strobe cycle's data and to insensitivity to configuration changes after acceptance. The bench measures each of these at the ports across random and directed accesses.

// File: rtl/hpi_rd_seq.sv
module hpi_rd_seq #(
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_addr,
  input  logic [PW-1:0] cfg_addr,
  input  logic [PW-1:0] cfg_setup,
  input  logic [PW-1:0] cfg_strobe,
  input  logic [PW-1:0] cfg_recov,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_cs_n,
  output logic          bus_ds_n,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_i,
  input  logic          tgt_wait
);
  localparam logic [PW-1:0] MIN_ADDR  = PW'(2);
  localparam logic [PW-1:0] MIN_SETUP = PW'(2);
  localparam logic [PW-1:0] MIN_STRB  = PW'(1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SETUP, S_STRB, S_RECOV} st_t;

  st_t           st, st_nx;
  logic [PW-1:0] cnt, lim;
  logic [PW-1:0] len_a, len_s, len_d, len_r;
  logic [DW-1:0] addr_q;
  logic          wait_q;

  function automatic logic [PW-1:0] atleast(input logic [PW-1:0] v, input logic [PW-1:0] m);
    return (v < m) ? m : v;
  endfunction

  assign req_ready = (st == S_IDLE);
  assign bus_cs_n  = !(st == S_ADDR || st == S_SETUP || st == S_STRB);
  assign bus_ds_n  = (st != S_STRB);
  assign bus_ad_oe = (st == S_ADDR);
  assign bus_ad_o  = (st == S_ADDR) ? addr_q : '0;

  wire held = (st == S_ADDR || st == S_STRB) && (tgt_wait || wait_q);
  wire done = (cnt == lim) && !held;

  always_comb begin
    lim   = len_r;
    st_nx = S_IDLE;
    case (st)
      S_ADDR:  begin lim = len_a; st_nx = S_SETUP; end
      S_SETUP: begin lim = len_s; st_nx = S_STRB;  end
      S_STRB:  begin lim = len_d; st_nx = S_RECOV; end
      default: begin lim = len_r; st_nx = S_IDLE;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      len_a     <= '0;
      len_s     <= '0;
      len_d     <= '0;
      len_r     <= '0;
      addr_q    <= '0;
      wait_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      wait_q    <= tgt_wait;
      rsp_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          len_a  <= atleast(cfg_addr, MIN_ADDR);
          len_s  <= atleast(cfg_setup, MIN_SETUP);
          len_d  <= atleast(cfg_strobe, MIN_STRB);
          len_r  <= cfg_recov;
          addr_q <= req_addr;
          cnt    <= '0;
          st     <= S_ADDR;
        end
      end else if (done) begin
        cnt <= '0;
        st  <= st_nx;
        if (st == S_STRB) begin
          rsp_data  <= bus_ad_i;
          rsp_valid <= 1'b1;
        end
      end else if (cnt != lim) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> bus_cs_n && bus_ds_n && req_ready); // R1
  AST_DS_IN_CS:   assert property (@(posedge clk) disable iff (!rst_n) !bus_ds_n |-> !bus_cs_n); // R2
  AST_ADDR_AT_CS: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_cs_n) |-> bus_ad_oe && bus_ad_o == addr_q); // R2
  AST_ADDR_MIN:   assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_ad_oe) |=> bus_ad_oe ##1 bus_ad_oe); // R3
  AST_STRB_MIN:   assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_ds_n) |=> !bus_ds_n); // R5
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !bus_cs_n |-> !req_ready); // R9
  AST_STALL_STRB: assert property (@(posedge clk) disable iff (!rst_n) !bus_ds_n && tgt_wait |=> !bus_ds_n); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bus_ds_n && $fell(tgt_wait) |=> !bus_ds_n); // R7
  AST_RSP_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> bus_cs_n && bus_ds_n && $past(!bus_ds_n)); // R8
  AST_RSP_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/hpi_rd_seq_bench.sv
module hpi_rd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [3:0]  cfg_addr = '0, cfg_setup = '0, cfg_strobe = '0, cfg_recov = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        bus_cs_n, bus_ds_n, bus_ad_oe;
  logic [15:0] bus_ad_o;
  logic [15:0] bus_ad_i = '0;
  logic        tgt_wait = 1'b0;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hpi_rd_seq #(.DW(16), .PW(4)) u_hpi_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cfg_addr(cfg_addr), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_recov(cfg_recov), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_cs_n(bus_cs_n), .bus_ds_n(bus_ds_n),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
    .tgt_wait(tgt_wait)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int phase_len(input int setting, input int minv, input int w);
    int n = (setting < minv) ? minv : setting;
    if (w > 0 && w + 2 > n + 1) return w + 2;
    return n + 1;
  endfunction

  task automatic run(input logic [15:0] a, input int ca, input int cs, input int cd,
                     input int cr, input int wa, input int ws);
    int na = 0, ns = 0, nd = 0, nr = 0, nrsp = 0, guard = 0;
    int exp_d;
    logic [15:0] got = '0;
    logic [15:0] base = 16'($urandom);
    bit addr_ok = 1'b1, ready_busy = 1'b0;
    @(negedge clk);
    cfg_addr = 4'(ca); cfg_setup = 4'(cs); cfg_strobe = 4'(cd); cfg_recov = 4'(cr);
    req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_addr = 4'($urandom); cfg_setup = 4'($urandom); cfg_strobe = 4'($urandom); cfg_recov = 4'($urandom);
    while (guard < 400) begin
      guard++;
      if (rsp_valid) begin nrsp++; got = rsp_data; end
      if (req_ready && !bus_cs_n) ready_busy = 1'b1;
      if (bus_ad_oe) begin
        if (bus_ad_o !== a || bus_cs_n) addr_ok = 1'b0;
        tgt_wait = (na < wa);
        na++;
      end else if (!bus_cs_n && bus_ds_n) begin
        tgt_wait = 1'b0;
        ns++;
      end else if (!bus_ds_n) begin
        tgt_wait = (nd < ws);
        bus_ad_i = base + 16'(nd);
        nd++;
      end else begin
        tgt_wait = 1'b0;
        if (req_ready) break;
        nr++;
      end
      @(negedge clk);
    end
    exp_d = phase_len(cd, 1, ws);
    chk(addr_ok, "R2 address on bus with chip select", int'(addr_ok), 1);
    chk(na == phase_len(ca, 2, wa), (wa > 0) ? "R7 address stall length" : "R3 address length", na, phase_len(ca, 2, wa));
    chk(ns == phase_len(cs, 2, 0), "R4 setup length", ns, phase_len(cs, 2, 0));
    chk(nd == exp_d, (ws > 0) ? "R7 strobe stall length" : "R5 strobe length", nd, exp_d);
    chk(nr == cr + 1, "R6 recovery length", nr, cr + 1);
    chk(nrsp == 1, "R8 response pulse count", nrsp, 1);
    chk(got == base + 16'(exp_d - 1), "R8 captured data", int'(got), int'(base + 16'(exp_d - 1)));
    chk(!ready_busy, "R9 ready low while busy", int'(ready_busy), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #2;
    chk(bus_cs_n === 1'b1 && bus_ds_n === 1'b1, "R1 reset strobes", int'({bus_cs_n, bus_ds_n}), 3);
    chk(bus_ad_oe === 1'b0 && req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset handshake",
        int'({bus_ad_oe, req_ready, rsp_valid}), 2);
    #30 rst_n = 1'b1;
    run(16'h1234, 0, 0, 0, 0, 0, 0);
    run(16'hBEEF, 15, 15, 15, 15, 0, 0);
    run(16'h0F0F, 2, 3, 1, 2, 4, 0);
    run(16'h5A5A, 3, 2, 1, 1, 0, 6);
    run(16'hC001, 6, 2, 5, 0, 1, 1);
    run(16'h8000, 1, 1, 0, 3, 1, 3);
    for (int i = 0; i < 60; i++)
      run(16'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
          int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
          (i % 3 == 0) ? int'($urandom_range(0, 6)) : 0,
          (i % 4 == 1) ? int'($urandom_range(0, 6)) : 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule